// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the serial output side of a sampling analog-to-digital converter, written as synchronous logic. A converter model hands it a result word and a busy flag. A host reads the word through an external serial clock, a chip select and a read enable. The serial clock is treated as an ordinary signal. It is synchronised and edge-detected against a faster system clock. The word leaves most significant bit first. Outgoing bits change on falling serial-clock edges, so the host samples them on rising edges.

A read can happen in one of two ways. The host picks between them by the moment of its first rising edge relative to busy:

- **Read after conversion.** If busy is low at that first rising edge, the host reads the freshly completed result. In this mode a daisy-chain input is latched on every rising edge and fed in behind the word. Several ports can then be cascaded on one data line.
- **Read during conversion.** If busy is high at that first rising edge, the host reads the previous result while the next conversion runs. The chain input is ignored. If the conversion ends before the read is finished, a one-cycle read-error pulse is raised.

Top module: `conv_serial_port`

## Requirements
- R1: While ext_sel is low, cs_n is high or rd_n is high, sdo is 0 and serial-clock edges are ignored.
- R2: Once selected, the MSB of the held word is on sdo. Each falling serial-clock edge that follows a rising edge moves the next lower bit onto sdo, so 16 rising edges deliver the whole word MSB first.
- R3: A falling edge that arrives before the first rising edge of a selection is ignored. A clock that rests high therefore reads the same word as one that rests low.
- R4: On the falling edge of busy, the result input is loaded into the output word, provided no read is in progress.
- R5: In read-after-conversion mode, chain_in is latched on each rising edge. From the 17th sampled bit onward, sdo carries those latched bits in order, so an upstream word follows the local LSB with no gap.
- R6: In read-during-conversion mode, the previous result is shifted out while busy is high, and the bits after the 16th are 0 whatever chain_in does.
- R7: A read is in progress when it has started and fewer than 16 bits have been shifted. If busy falls while a read is in progress, rd_err is high for exactly one system-clock cycle. Otherwise rd_err stays low.
- R8: When busy falls during a read in progress, the load is deferred. The remaining bits of the word being read are unchanged, and the new result is loaded once the read finishes or is deselected. A read started after one conversion may continue across the start of the next one.
- R9: Raising cs_n clears the bit count and restores the held word, so the next selection reads the whole word again from its MSB.
- R10: Raising rd_n or lowering ext_sel in the middle of a read freezes it. When the port is enabled again, the read continues from the bit where it stopped.
- R11: After reset, sdo and rd_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low reset |
| ext_sel | input | 1 | High to take the serial clock from the sclk pin |
| sclk | input | 1 | External serial clock, sampled against clk |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read enable |
| chain_in | input | 1 | Daisy-chain data from an upstream port |
| busy | input | 1 | High while the converter model is converting |
| result | input | DATA_W | Conversion result, valid when busy falls |
| sdo | output | 1 | Serial data out |
| rd_err | output | 1 | One-cycle pulse when a read is cut short by end of conversion |

## Verification
A wrong bit count shows up within one serial-clock period. The word arrives shifted, or the chain bits start at the wrong position in a 32-bit read. A lost or early load shows up at the next read: the host sees the old word, or a word that changes in the middle of a read across the end of busy. A wrong in-progress flag shows up within one system cycle of busy falling, as a missing or spurious rd_err pulse.

// File: rtl/conv_serial_pkg.sv
package conv_serial_pkg;
   typedef enum logic {
      RD_AFTER  = 1'b0,
      RD_DURING = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/conv_serial_edge.sv
module conv_serial_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic rise,
   output logic fall
);
   logic sig_s;
   logic sig_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sig_s = sig_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else if (SYNC_STAGES == 1) stage_q <= sig_in;
            else stage_q <= {stage_q[SYNC_STAGES-2:0], sig_in};
         end
         assign sig_s = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_prev <= 1'b0;
      else        sig_prev <= sig_s;
   end

   assign rise = sig_s & ~sig_prev;
   assign fall = ~sig_s & sig_prev;
endmodule

// File: rtl/conv_serial_seq.sv
module conv_serial_seq
   import conv_serial_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_sel,
   input  logic             cs_n,
   input  logic             rd_n,
   input  logic             busy,
   input  logic             sclk_rise,
   input  logic             sclk_fall,
   output logic             load_en,
   output logic             restore,
   output logic             shift_en,
   output logic             capture_en,
   output logic             chain_use,
   output logic             in_prog,
   output logic [CNT_W-1:0] cnt,
   output logic             rd_err
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

   logic       busy_q;
   logic       pend_q;
   logic       armed_q;
   rd_mode_e   mode_q;
   logic       sel;
   logic       act;
   logic       busy_fall;
   logic       arm_now;

   always_comb begin
      sel        = ~cs_n;
      act        = ext_sel & sel & ~rd_n;
      in_prog    = armed_q & (cnt < FULL);
      busy_fall  = busy_q & ~busy;
      load_en    = (busy_fall | pend_q) & ~in_prog;
      restore    = ~sel;
      arm_now    = act & sclk_rise & ~armed_q & ~load_en;
      capture_en = act & sclk_rise & ~load_en;
      shift_en   = act & sclk_fall & armed_q & ~load_en;
      chain_use  = armed_q & (mode_q == RD_AFTER);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         pend_q  <= 1'b0;
         rd_err  <= 1'b0;
         armed_q <= 1'b0;
         mode_q  <= RD_AFTER;
         cnt     <= '0;
      end else begin
         busy_q <= busy;
         rd_err <= busy_fall & in_prog;
         if (load_en)        pend_q <= 1'b0;
         else if (busy_fall) pend_q <= 1'b1;
         if (!sel || load_en) begin
            armed_q <= 1'b0;
            cnt     <= '0;
         end else begin
            if (arm_now) begin
               armed_q <= 1'b1;
               mode_q  <= busy ? RD_DURING : RD_AFTER;
            end
            if (shift_en && cnt < FULL) cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/conv_serial_shift.sv
module conv_serial_shift #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              restore,
   input  logic              shift_en,
   input  logic              capture_en,
   input  logic              chain_use,
   input  logic              chain_in,
   input  logic [DATA_W-1:0] result,
   output logic [DATA_W-1:0] hold,
   output logic              msb
);
   logic [DATA_W-1:0] sh_q;
   logic              chain_q;
   logic              fill_bit;

   assign fill_bit = chain_q & chain_use;
   assign msb      = sh_q[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold    <= '0;
         sh_q    <= '0;
         chain_q <= 1'b0;
      end else begin
         if (capture_en) chain_q <= chain_in;
         if (load_en) begin
            hold <= result;
            sh_q <= result;
         end else if (restore) begin
            sh_q <= hold;
         end else if (shift_en) begin
            sh_q <= {sh_q[DATA_W-2:0], fill_bit};
         end
      end
   end
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port #(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_sel,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              chain_in,
   input  logic              busy,
   input  logic [DATA_W-1:0] result,
   output logic              sdo,
   output logic              rd_err
);
   localparam int CNT_W = $clog2(DATA_W + 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("conv_serial_port: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("conv_serial_port: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic              sclk_rise;
   logic              sclk_fall;
   logic              load_en;
   logic              restore;
   logic              shift_en;
   logic              capture_en;
   logic              chain_use;
   logic              in_prog;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] hold;
   logic              msb;

   conv_serial_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_in(sclk),
      .rise  (sclk_rise),
      .fall  (sclk_fall)
   );

   conv_serial_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_sel   (ext_sel),
      .cs_n      (cs_n),
      .rd_n      (rd_n),
      .busy      (busy),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .load_en   (load_en),
      .restore   (restore),
      .shift_en  (shift_en),
      .capture_en(capture_en),
      .chain_use (chain_use),
      .in_prog   (in_prog),
      .cnt       (cnt),
      .rd_err    (rd_err)
   );

   conv_serial_shift #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .restore   (restore),
      .shift_en  (shift_en),
      .capture_en(capture_en),
      .chain_use (chain_use),
      .chain_in  (chain_in),
      .result    (result),
      .hold      (hold),
      .msb       (msb)
   );

   assign sdo = (ext_sel & ~cs_n & ~rd_n) ? msb : 1'b0;
endmodule

// File: rtl/conv_serial_port_chk.sv
module conv_serial_port_chk #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              busy,
   input logic              rd_err,
   input logic              load_en,
   input logic              in_prog,
   input logic [CNT_W-1:0]  cnt,
   input logic [DATA_W-1:0] hold,
   input logic [DATA_W-1:0] result
);
   // R7
   err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |=> !rd_err);

   // R7
   err_after_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> ($past(busy, 2) && !$past(busy)));

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DATA_W));

   // R9
   deselect_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (cnt == '0));

   // R4
   load_takes_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (hold == $past(result)));

   // R8
   hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_prog |=> $stable(hold));
endmodule

bind conv_serial_port conv_serial_port_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_n   (cs_n),
   .busy   (busy),
   .rd_err (rd_err),
   .load_en(load_en),
   .in_prog(in_prog),
   .cnt    (cnt),
   .hold   (hold),
   .result (result)
);

// File: tb/conv_serial_port_bench.sv
module conv_serial_port_bench;
   localparam int H = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_sel = 1'b1;
   logic        sclk = 1'b0;
   logic        cs_n = 1'b1;
   logic        rd_n = 1'b0;
   logic        chain_in = 1'b0;
   logic        busy = 1'b0;
   logic [15:0] result = '0;
   logic        sdo;
   logic        rd_err;

   int n_chk = 0;
   int n_bad = 0;
   int err_cycles = 0;
   bit done = 0;

   always #4 clk = ~clk;

   conv_serial_port u_conv_serial_port (
      .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .sclk(sclk), .cs_n(cs_n),
      .rd_n(rd_n), .chain_in(chain_in), .busy(busy), .result(result),
      .sdo(sdo), .rd_err(rd_err)
   );

   always @(posedge clk) if (rst_n && rd_err) err_cycles++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_h();
      repeat (H) @(negedge clk);
   endtask

   task automatic pulse();
      sclk = 1'b1; wait_h(); sclk = 1'b0; wait_h();
   endtask

   task automatic read_bits(input int n, input logic [15:0] up, output logic [31:0] got);
      got = '0;
      for (int i = 0; i < n; i++) begin
         got = {got[30:0], sdo};
         chain_in = (i < 16) ? up[15 - i] : 1'b0;
         pulse();
      end
   endtask

   task automatic convert(input logic [15:0] v);
      busy = 1'b1;
      repeat (20) @(negedge clk);
      result = v;
      busy = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic select();
      cs_n = 1'b0; wait_h();
   endtask

   task automatic deselect();
      cs_n = 1'b1; wait_h();
   endtask

   task automatic finish_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_up();
      end
   end

   initial begin
      logic [31:0] got;
      logic [31:0] g2;
      logic [15:0] v;
      int e0;
      repeat (5) @(negedge clk);
      // R11 reset state
      chk("R11 sdo", {31'd0, sdo}, 32'd0);
      chk("R11 rd_err", {31'd0, rd_err}, 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1: disabled port drives 0
      convert(16'hFFFF);
      ext_sel = 1'b0; select();
      chk("R1 ext_sel low", {31'd0, sdo}, 32'd0);
      ext_sel = 1'b1; rd_n = 1'b1; wait_h();
      chk("R1 rd_n high", {31'd0, sdo}, 32'd0);
      rd_n = 1'b0; deselect();
      chk("R1 cs_n high", {31'd0, sdo}, 32'd0);

      // R2 R4: walking ones/zeros and patterns, read after conversion
      for (int k = 0; k < 36; k++) begin
         if (k < 16)      v = 16'h1 << k;
         else if (k < 32) v = ~(16'h1 << (k - 16));
         else if (k == 32) v = 16'hA5C3;
         else if (k == 33) v = 16'h0000;
         else if (k == 34) v = 16'h8001;
         else              v = 16'h3C5A;
         convert(v);
         select();
         read_bits(16, ~v, got);
         chk("R2 R4 word", got, {16'd0, v});
         deselect();
      end

      // R3: clock resting high, leading fall ignored
      convert(16'hC0DE);
      sclk = 1'b1; wait_h();
      select();
      sclk = 1'b0; wait_h();
      read_bits(16, 16'h0, got);
      sclk = 1'b1; wait_h();
      chk("R3 idle-high word", got, {16'd0, 16'hC0DE});
      deselect();
      sclk = 1'b0; wait_h();

      // R5: daisy chain, upstream word follows local LSB
      for (int k = 0; k < 4; k++) begin
         v = 16'h1234 + 16'(k * 16'h1111);
         convert(v);
         select();
         read_bits(32, ~v ^ 16'(k), got);
         chk("R5 chained pair", got, {v, ~v ^ 16'(k)});
         deselect();
      end

      // R6: read previous result during conversion, chain ignored
      convert(16'hBEEF);
      e0 = err_cycles;
      busy = 1'b1; wait_h();
      select();
      read_bits(32, 16'hFFFF, got);
      chk("R6 previous word then zeros", got, {16'hBEEF, 16'h0000});
      deselect();
      result = 16'h4242; busy = 1'b0; repeat (4) @(negedge clk);
      chk("R7 no error on complete read", err_cycles - e0, 0);
      select();
      read_bits(16, 16'h0, got);
      chk("R4 new word after conversion", got, {16'd0, 16'h4242});
      deselect();

      // R7 R8: read during conversion cut short
      e0 = err_cycles;
      busy = 1'b1; wait_h();
      select();
      read_bits(8, 16'h0, got);
      result = 16'h9A7E; busy = 1'b0; repeat (4) @(negedge clk);
      chk("R7 one-cycle error pulse", err_cycles - e0, 1);
      read_bits(8, 16'h0, g2);
      chk("R8 bits unchanged by deferred load", {got[7:0], g2[7:0]}, {16'd0, 16'h4242});
      deselect();
      select();
      read_bits(16, 16'h0, got);
      chk("R8 deferred load visible", got, {16'd0, 16'h9A7E});
      deselect();

      // R8: read across the start of the next conversion
      convert(16'h5EED);
      e0 = err_cycles;
      select();
      read_bits(8, 16'h0, got);
      busy = 1'b1; wait_h();
      read_bits(8, 16'h0, g2);
      chk("R8 word across conversion start", {got[7:0], g2[7:0]}, {16'd0, 16'h5EED});
      result = 16'h0F0F; busy = 1'b0; repeat (4) @(negedge clk);
      chk("R7 no error after finished read", err_cycles - e0, 0);
      read_bits(16, 16'h0, got);
      chk("R4 load while selected", got, {16'd0, 16'h0F0F});
      deselect();

      // R9: deselect mid-read restores the word
      select();
      read_bits(5, 16'h0, got);
      deselect(); select();
      read_bits(16, 16'h0, got);
      chk("R9 full re-read", got, {16'd0, 16'h0F0F});
      deselect();

      // R10: rd_n and ext_sel pauses
      convert(16'hD00B);
      select();
      read_bits(6, 16'h0, got);
      rd_n = 1'b1; wait_h();
      for (int p = 0; p < 3; p++) pulse();
      rd_n = 1'b0; wait_h();
      read_bits(10, 16'h0, g2);
      chk("R10 rd_n pause", {16'd0, got[5:0], g2[9:0]}, {16'd0, 16'hD00B});
      deselect(); select();
      read_bits(9, 16'h0, got);
      ext_sel = 1'b0; wait_h();
      for (int p = 0; p < 4; p++) pulse();
      ext_sel = 1'b1; wait_h();
      read_bits(7, 16'h0, g2);
      chk("R10 ext_sel pause", {16'd0, got[8:0], g2[6:0]}, {16'd0, 16'hD00B});
      deselect();

      done = 1;
      finish_up();
   end
endmodule